// File: doc/BRIEF.md
# Four-Channel DMA Controller with Pointer-Indirect Channel

The controller moves words between locations on one shared memory bus on behalf of four channels. Each channel is set up through a common configuration bus. A setup gives the channel a source address, a destination address, a transfer count and a six-bit mode word. The channel then waits for its request line. A normal transfer reads the source and then writes the same word to the destination. The two lowest channels can instead run one-cycle single-address transfers. In that mode the read word goes out to an external device, and an acknowledge line marks the bus cycle. Channel 2 can loop over its source block again and again. Channel 3 can treat the word it reads as a pointer to the real data.

A channel either releases the bus after every transfer (cycle-steal) or keeps it until its count runs out (burst). When several channels request at once, an arbiter picks one. It uses either fixed order or a rotating order. When the last transfer of a count finishes, the channel drops its busy line and raises its end-of-transfer flag. The flag stays set until that channel is set up again.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, `mem_req` is low, every `ch_busy` bit is low and every `eot_irq` bit is low.
- R2: A pulse on `cfg_load[i]` with a non-zero `cfg_cnt` makes `ch_busy[i]` high and clears `eot_irq[i]` on the next cycle. A zero count leaves the channel idle.
- R3: A dual-address transfer reads `src` and then writes that word to `dst`. After each transfer, `src` advances by 1 if mode bit 1 is set and `dst` advances by 1 if mode bit 2 is set; otherwise each stays where it is.
- R4: In single-address mode (mode bit 3, channels 0 and 1 only), each transfer is one read of `src`, and `dack[i]` is high during that cycle. No write takes place.
- R5: After `cfg_cnt` transfers, `ch_busy[i]` drops and `eot_irq[i]` is set.
- R6: In cycle-steal mode (mode bit 0 clear), a transfer starts only while the channel's request is high, and `mem_req` goes low for at least one cycle between transfers.
- R7: In burst mode (mode bit 0 set), one request starts the channel, and all of its transfers follow back to back with `mem_req` held high.
- R8: With `prio_rr` low, the lowest-numbered channel that is both requesting and busy wins the bus.
- R9: With `prio_rr` high, the search for the next winner starts at the channel just after the last one served.
- R10: Channel 2 with reload (mode bit 4) restores its source address and count each time the count runs out. It sets `eot_irq[2]` and keeps `ch_busy[2]` high.
- R11: Channel 3 with indirect mode (mode bit 5) reads `src`, takes the low address bits of that word as a pointer, reads the pointer location, and then writes that word to `dst`.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R13: Mode bits that a channel does not support have no effect: single on channels 2 and 3, reload outside channel 2, and indirect outside channel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 4 | Per-channel setup strobe |
| cfg_src | input | AW | Source address for setup |
| cfg_dst | input | AW | Destination address for setup |
| cfg_cnt | input | CW | Transfer count for setup |
| cfg_mode | input | 6 | Mode bits: 0 burst, 1 src advance, 2 dst advance, 3 single, 4 reload, 5 indirect |
| prio_rr | input | 1 | 0 = fixed priority, 1 = rotating priority |
| ext_dreq | input | 2 | Request lines of channels 0 and 1 |
| per_dreq | input | 2 | Request lines of channels 2 and 3 |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Bus cycle completes this clock |
| dack | output | 2 | Single-address acknowledge for channels 0 and 1 |
| ch_busy | output | 4 | Channel enabled |
| eot_irq | output | 4 | End-of-transfer flags |

## Verification
The assertions assume that a channel is never set up again while it is busy. They also assume that the bus returns `mem_ready` only while `mem_req` is high. The stimulus keeps within these limits. It resets the block before each scenario and loads channels only while their requests are low and the bus is idle. Its memory model raises `mem_ready` only for a pending cycle, after a fixed number of wait cycles. Under those limits the assertions check that the bus holds steady across wait states and that the fixed-order arbiter never skips a lower channel. They also check that a busy channel always has a non-zero count and that it stops only at the end of its count.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH = 4;
    localparam int MW  = 6;

    // Packed from MSB: bit5 indirect ... bit0 burst
    typedef struct packed {
        logic indirect;
        logic reload;
        logic single;
        logic dst_inc;
        logic src_inc;
        logic burst;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_DATA = 2'd2,
        ST_WR   = 2'd3
    } st_e;
endpackage

// File: rtl/dma4_channel.sv
module dma4_channel
    import dma4_pkg::*;
#(
    parameter int AW           = 16,
    parameter int CW           = 8,
    parameter bit CAN_SINGLE   = 1'b0,
    parameter bit CAN_RELOAD   = 1'b0,
    parameter bit CAN_INDIRECT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  mode_t         cfg_mode,
    input  logic          done,
    output logic          en,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output mode_t         mode,
    output logic          last,
    output logic          eot
);
    typedef struct packed {
        logic          en;
        logic          eot;
        logic [AW-1:0] src;
        logic [AW-1:0] src0;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cnt0;
        mode_t         mode;
    } chan_t;

    chan_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.mode          = cfg_mode;
            d.mode.single   = cfg_mode.single & CAN_SINGLE;
            d.mode.reload   = cfg_mode.reload & CAN_RELOAD;
            d.mode.indirect = cfg_mode.indirect & CAN_INDIRECT;
            d.src  = cfg_src;
            d.src0 = cfg_src;
            d.dst  = cfg_dst;
            d.cnt  = cfg_cnt;
            d.cnt0 = cfg_cnt;
            d.en   = (cfg_cnt != '0);
            d.eot  = 1'b0;
        end else if (done) begin
            if (q.mode.src_inc) d.src = q.src + AW'(1);
            if (q.mode.dst_inc) d.dst = q.dst + AW'(1);
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.eot = 1'b1;
                if (q.mode.reload) begin
                    d.src = q.src0;
                    d.cnt = q.cnt0;
                end else begin
                    d.en = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en   = q.en;
    assign src  = q.src;
    assign dst  = q.dst;
    assign mode = q.mode;
    assign last = (q.cnt == CW'(1));
    assign eot  = q.eot;

    a_r5_busy_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        q.en |-> q.cnt != '0);
    a_r5_stop_only_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.en) |-> $past(done));
    a_r2_done_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> q.en);
    a_r10_reload_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last && q.mode.reload && !load) |=> q.en && q.eot);
endmodule

// File: rtl/dma4_arbiter.sv
module dma4_arbiter
    import dma4_pkg::*;
#(
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] pending,
    input  logic           rr,
    input  logic [IW-1:0]  last_ch,
    output logic           any,
    output logic [IW-1:0]  gnt
);
    always_comb begin
        any = 1'b0;
        gnt = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [IW-1:0] k;
            k = rr ? IW'(last_ch + IW'(i + 1)) : IW'(i);
            if (!any && pending[k]) begin
                any = 1'b1;
                gnt = k;
            end
        end
    end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int IW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    any,
    input  logic [IW-1:0]           gnt,
    input  logic [NCH-1:0][AW-1:0]  ch_src,
    input  logic [NCH-1:0][AW-1:0]  ch_dst,
    input  mode_t [NCH-1:0]         ch_mode,
    input  logic [NCH-1:0]          ch_last,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    output logic [NCH-1:0]          done,
    output logic [1:0]              dack,
    output logic [IW-1:0]           last_ch
);
    typedef struct packed {
        st_e           st;
        logic [IW-1:0] ch;
        logic [IW-1:0] last_ch;
        logic [DW-1:0] data;
        logic [AW-1:0] xaddr;
    } eng_t;

    eng_t  q, d;
    mode_t m;
    logic  fin;

    assign m = ch_mode[q.ch];

    always_comb begin
        d    = q;
        fin  = 1'b0;
        done = '0;
        unique case (q.st)
            ST_IDLE: if (any) begin
                d.ch = gnt;
                d.st = ST_RD;
            end
            ST_RD: if (mem_ready) begin
                if (m.single) begin
                    fin = 1'b1;
                end else if (m.indirect) begin
                    d.xaddr = mem_rdata[AW-1:0];
                    d.st    = ST_DATA;
                end else begin
                    d.data = mem_rdata;
                    d.st   = ST_WR;
                end
            end
            ST_DATA: if (mem_ready) begin
                d.data = mem_rdata;
                d.st   = ST_WR;
            end
            ST_WR: if (mem_ready) fin = 1'b1;
            default: d.st = ST_IDLE;
        endcase
        if (fin) begin
            done[q.ch] = 1'b1;
            d.last_ch  = q.ch;
            d.st       = (m.burst && !ch_last[q.ch]) ? ST_RD : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.last_ch <= IW'(NCH - 1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req   = (q.st != ST_IDLE);
        mem_we    = (q.st == ST_WR);
        mem_wdata = q.data;
        unique case (q.st)
            ST_DATA: mem_addr = q.xaddr;
            ST_WR:   mem_addr = ch_dst[q.ch];
            default: mem_addr = ch_src[q.ch];
        endcase
        for (int i = 0; i < 2; i++)
            dack[i] = (q.st == ST_RD) && m.single && (q.ch == IW'(i));
    end

    assign last_ch = q.last_ch;

    a_r12_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata));
    a_r5_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));
    a_r7_burst_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0 && m.burst && !ch_last[q.ch]) |=> mem_req);
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cfg_load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic [5:0]    cfg_mode,
    input  logic          prio_rr,
    input  logic [1:0]    ext_dreq,
    input  logic [1:0]    per_dreq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic [1:0]    dack,
    output logic [3:0]    ch_busy,
    output logic [3:0]    eot_irq
);
    localparam int IW = $clog2(NCH);

    logic [NCH-1:0][AW-1:0] ch_src, ch_dst;
    mode_t [NCH-1:0]        ch_mode;
    logic [NCH-1:0]         ch_en, ch_last, ch_eot, ch_done, pending;
    logic                   arb_any;
    logic [IW-1:0]          arb_gnt, last_ch;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma4_channel #(
            .AW(AW), .CW(CW),
            .CAN_SINGLE(c < 2), .CAN_RELOAD(c == 2), .CAN_INDIRECT(c == 3)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .load(cfg_load[c]),
            .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
            .cfg_mode(mode_t'(cfg_mode)), .done(ch_done[c]),
            .en(ch_en[c]), .src(ch_src[c]), .dst(ch_dst[c]),
            .mode(ch_mode[c]), .last(ch_last[c]), .eot(ch_eot[c])
        );
    end

    assign pending = ch_en & {per_dreq, ext_dreq};

    dma4_arbiter u_arb (
        .pending(pending), .rr(prio_rr), .last_ch(last_ch),
        .any(arb_any), .gnt(arb_gnt)
    );

    dma4_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .any(arb_any), .gnt(arb_gnt),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_mode(ch_mode), .ch_last(ch_last),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(ch_done), .dack(dack), .last_ch(last_ch)
    );

    assign ch_busy = ch_en;
    assign eot_irq = ch_eot;

    a_r8_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_any && !prio_rr) |-> (pending & ((NCH'(1) << arb_gnt) - NCH'(1))) == '0);
    a_r4_dack_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != 2'b00) |-> mem_req && !mem_we);
    a_r4_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));
endmodule

// File: tb/sim_dma4_ctrl.sv
module sim_dma4_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, DW = 16, CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_load = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic [5:0]    cfg_mode = '0;
    logic          prio_rr = 1'b0;
    logic [1:0]    ext_dreq = '0, per_dreq = '0;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [1:0]    dack;
    logic [3:0]    ch_busy, eot_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma4_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

    function automatic logic [15:0] f(int a);
        return 16'(a * 37 + 5);
    endfunction

    // memory model and bus log
    logic [DW-1:0] mem [256];
    int ws = 0, wcnt, log_n, rises;
    logic req_prev;
    logic [63:0] lg [64];

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = mem_req && (wcnt >= ws);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= f(a);
            wcnt <= 0; log_n <= 0; rises <= 0; req_prev <= 1'b0;
        end else begin
            req_prev <= mem_req;
            if (mem_req && !req_prev) rises <= rises + 1;
            wcnt <= (mem_req && !mem_ready) ? wcnt + 1 : 0;
            if (mem_ready) begin
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                if (log_n < 64)
                    lg[log_n] <= {29'd0, mem_we, dack, mem_addr, mem_we ? mem_wdata : mem_rdata};
                log_n <= log_n + 1;
            end
        end
    end

    // expected model
    logic [15:0] exp_mem [256];
    logic [63:0] ex [64];
    int ex_n, n_chk = 0, n_fail = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(bit we, logic [1:0] dk, logic [15:0] a, logic [15:0] dt);
        ex[ex_n] = {29'd0, we, dk, a, dt};
        ex_n++;
    endtask

    task automatic exp_dual(int s, int t);
        logic [15:0] v;
        v = exp_mem[s & 255];
        push(1'b0, 2'b00, 16'(s), v);
        push(1'b1, 2'b00, 16'(t), v);
        exp_mem[t & 255] = v;
    endtask

    task automatic exp_ind(int s, int t);
        logic [15:0] p, v;
        p = exp_mem[s & 255];
        v = exp_mem[p[7:0]];
        push(1'b0, 2'b00, 16'(s), p);
        push(1'b0, 2'b00, p, v);
        push(1'b1, 2'b00, 16'(t), v);
        exp_mem[t & 255] = v;
    endtask

    task automatic check_log(string req);
        chk(log_n == ex_n, req, "bus op count", log_n, ex_n);
        for (int i = 0; i < ex_n && i < 64; i++)
            chk(lg[i] == ex[i], req, $sformatf("bus op %0d {we,dack,addr,data}", i), lg[i], ex[i]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_load = '0; ext_dreq = '0; per_dreq = '0; prio_rr = 1'b0; ws = 0;
        for (int a = 0; a < 256; a++) exp_mem[a] = f(a);
        ex_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(int c, int s, int t, int n, logic [5:0] md);
        @(negedge clk);
        cfg_src = AW'(s); cfg_dst = AW'(t); cfg_cnt = CW'(n); cfg_mode = md;
        cfg_load = 4'(1 << c);
        @(negedge clk);
        cfg_load = '0;
    endtask

    task automatic wait_quiet(logic [3:0] mask);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ((ch_busy & mask) == 0 && !mem_req) break;
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(!mem_req && ch_busy == 0 && eot_irq == 0, "R1", "reset {req,busy,eot}",
            {mem_req, ch_busy, eot_irq}, 0);

        // R3 R5 R6 R12: ch0 dual, cycle-steal, one wait state
        do_reset(); ws = 1;
        load(0, 8'h00, 8'h80, 3, 6'b000110);
        chk(ch_busy == 4'b0001, "R2", "busy after load", ch_busy, 1);
        ext_dreq = 2'b01;
        wait_quiet(4'b0001);
        ext_dreq = 2'b00;
        for (int k = 0; k < 3; k++) exp_dual(k, 8'h80 + k);
        check_log("R3 R12");
        chk(rises == 3, "R6", "bus grabs in cycle-steal", rises, 3);
        chk(ch_busy == 0 && eot_irq == 4'b0001, "R5", "{busy,eot} after count",
            {ch_busy, eot_irq}, 1);

        // R4: ch1 single-address
        do_reset();
        load(1, 8'h30, 8'h00, 2, 6'b001010);
        ext_dreq = 2'b10;
        wait_quiet(4'b0010);
        ext_dreq = 2'b00;
        for (int k = 0; k < 2; k++) push(1'b0, 2'b10, 16'(8'h30 + k), exp_mem[8'h30 + k]);
        check_log("R4");
        chk(rises == 2 && eot_irq == 4'b0010, "R4", "{rises,eot}", {rises, eot_irq}, {32'd2, 4'b0010});

        // R7 R3: ch2 burst, fixed source, advancing destination, single request pulse
        do_reset(); ws = 2;
        load(2, 8'h40, 8'hA0, 4, 6'b000101);
        per_dreq = 2'b01;
        @(negedge clk);
        per_dreq = 2'b00;
        wait_quiet(4'b0100);
        for (int k = 0; k < 4; k++) exp_dual(8'h40, 8'hA0 + k);
        check_log("R7 R3");
        chk(rises == 1, "R7", "bus grabs in burst", rises, 1);

        // R10: ch2 source reload
        do_reset();
        load(2, 8'h50, 8'hB0, 2, 6'b010110);
        per_dreq = 2'b01;
        while (log_n < 10) @(negedge clk);
        per_dreq = 2'b00;
        repeat (5) @(negedge clk);
        for (int k = 0; k < 5; k++) exp_dual(8'h50 + (k % 2), 8'hB0 + k);
        check_log("R10");
        chk(ch_busy == 4'b0100 && eot_irq == 4'b0100, "R10", "{busy,eot} after reloads",
            {ch_busy, eot_irq}, {4'b0100, 4'b0100});

        // R11: ch3 indirect
        do_reset(); ws = 2;
        load(3, 8'h10, 8'hC0, 3, 6'b100110);
        per_dreq = 2'b10;
        wait_quiet(4'b1000);
        per_dreq = 2'b00;
        for (int k = 0; k < 3; k++) exp_ind(8'h10 + k, 8'hC0 + k);
        check_log("R11");

        // R8 fixed and R9 rotating priority
        for (int r = 0; r < 2; r++) begin
            do_reset();
            prio_rr = 1'(r);
            for (int c = 0; c < 4; c++) load(c, 8'h20 + 8 * c, 8'h90 + 8 * c, 2, 6'b000110);
            ext_dreq = 2'b11; per_dreq = 2'b11;
            wait_quiet(4'b1111);
            ext_dreq = 2'b00; per_dreq = 2'b00;
            if (r == 0) begin
                for (int c = 0; c < 4; c++)
                    for (int k = 0; k < 2; k++) exp_dual(8'h20 + 8 * c + k, 8'h90 + 8 * c + k);
                check_log("R8");
            end else begin
                for (int k = 0; k < 2; k++)
                    for (int c = 0; c < 4; c++) exp_dual(8'h20 + 8 * c + k, 8'h90 + 8 * c + k);
                check_log("R9");
            end
            chk(eot_irq == 4'b1111, "R5", "all channels ended", eot_irq, 4'b1111);
        end

        // R13: unsupported mode bits ignored
        do_reset();
        load(2, 8'h60, 8'hD0, 1, 6'b101110);
        load(0, 8'h61, 8'hD1, 1, 6'b010110);
        per_dreq = 2'b01; ext_dreq = 2'b01;
        wait_quiet(4'b0101);
        per_dreq = 2'b00; ext_dreq = 2'b00;
        exp_dual(8'h61, 8'hD1);
        exp_dual(8'h60, 8'hD0);
        check_log("R13");
        chk(ch_busy == 0 && eot_irq == 4'b0101, "R13", "{busy,eot} no reload on ch0",
            {ch_busy, eot_irq}, 5);

        // R2: zero count, flag cleared by load; R6: no request, no bus
        do_reset();
        load(0, 0, 8'hE0, 0, 6'b000110);
        chk(ch_busy == 0, "R2", "zero count stays idle", ch_busy, 0);
        load(0, 0, 8'hE0, 1, 6'b000110);
        ext_dreq = 2'b01;
        wait_quiet(4'b0001);
        ext_dreq = 2'b00;
        chk(eot_irq == 4'b0001, "R5", "eot set", eot_irq, 1);
        load(0, 4, 8'hE4, 1, 6'b000110);
        chk(eot_irq == 0 && ch_busy == 4'b0001, "R2", "{busy,eot} after reload of setup",
            {ch_busy, eot_irq}, {4'b0001, 4'b0000});
        repeat (20) @(negedge clk);
        chk(rises == 1 && !mem_req, "R6", "no bus cycle without request", rises, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule